// File: doc/BRIEF.md
# Multiplexed LED Matrix PWM Scanner

This block keeps a brightness value for every LED of a row-multiplexed matrix and refreshes the matrix without pause. The LEDs hang off a set of identical 16-channel constant-current driver chips. Each chip has its own serial data line, and all chips share one shift clock and one latch strobe. Each chip serves several rows in turn, and a one-hot row select drives the row switch transistors. Because all chips shift at the same moment, the shift clock runs at the per-chip rate instead of at a rate multiplied by the chip count.

For each row, the scanner walks the 16 channels from the highest channel down. It compares each LED's stored duty value with a shared PWM level and shifts the resulting on/off bit into every chip at once. It then strobes the latch and blanks the outputs for a guard time while the row select moves on. The PWM level steps once per complete pass over all rows.

A host write port updates one LED at a time, whenever it likes. With double buffering enabled, writes land in a back copy. The whole back copy is transferred into the displayed copy only when the PWM level wraps, so a displayed frame is never a mix of old and new values.

Top module: `led_scan_core`

## Requirements
- R1: While reset is held, `drv_blank` is 1, `drv_sclk` and `drv_latch` are 0, and `row_sel` is 1 (row 0 selected).
- R2: For each row, every chip receives 16 data bits, channel 15 first and channel 0 last. Each bit is valid at a rising edge of `drv_sclk`, and it is 1 exactly when the LED's stored duty is less than the current PWM level.
- R3: After the 16th shift clock of a row, `drv_latch` is high for exactly one cycle. During that cycle `drv_sclk` and `drv_blank` are low.
- R4: In the cycle after the latch, `row_sel` switches to the one-hot code of the row just shifted, and `drv_blank` stays high for exactly BLANK_CYC cycles. Rows are shifted in the order 0, 1, ..., ROWS-1 and then repeat. `row_sel` only ever changes while blanked.
- R5: The PWM level starts at 0. It rises by one after the latch of row ROWS-1, stays constant at all other times, and wraps from 2^DUTY_W-1 to 0.
- R6: A write with `wr_en`=1 stores `wr_duty` for the LED at chip `wr_chip`, row `wr_row`, channel `wr_ch`, and leaves every other LED unchanged.
- R7: With DOUBLE_BUF=1, writes go to a back copy. The displayed copy becomes a complete copy of the back copy at the clock edge where the PWM level wraps. A write in that same cycle reaches the back copy only, and appears one frame later.
- R8: Each chip's data line carries that chip's own LED values. All chips share the same shift clock and latch.
- R9: During shifting, `drv_sclk` rises once every 2 clock cycles. The data lines do not change in the cycle where `drv_sclk` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Host write strobe for one LED |
| wr_chip | input | CHIP_W | Driver chip index of the written LED |
| wr_row | input | ROW_W | Row index of the written LED |
| wr_ch | input | CH_W | Channel index of the written LED |
| wr_duty | input | DUTY_W | Duty value to store |
| drv_sclk | output | 1 | Shared shift clock to all driver chips |
| drv_sdat | output | CHIPS | One serial data line per driver chip |
| drv_latch | output | 1 | Shared one-cycle latch strobe |
| drv_blank | output | 1 | Output blanking during the row change guard time |
| row_sel | output | ROWS | One-hot row switch select |

## Verification
The hardest case to reach from the ports is a host write that lands in the one cycle where the displayed copy is refreshed from the back copy. That cycle exists only once per frame, at the latch of the last row at the top PWM level. The bench tracks rows and PWM levels from the latches it observes. It waits for the latch of the next-to-last row at the top level, counts the known latch-to-latch period, and places a write exactly in the wrap cycle. A reference model then predicts every row's bits for the following two frames, which shows that the write was held back by exactly one frame.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;

  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LATCH = 2'd2
  } scan_state_t;

  // An LED is lit when its duty is strictly below the PWM level.
  function automatic logic led_lit(int unsigned duty, int unsigned level);
    return duty < level;
  endfunction

  // Next row in the refresh order, wrapping after the last row.
  function automatic int unsigned row_after(int unsigned row, int unsigned rows);
    return (row + 1 >= rows) ? 0 : row + 1;
  endfunction

  // Flat store index of an LED inside one chip's bank.
  function automatic int unsigned led_index(int unsigned row, int unsigned ch, int unsigned chans);
    return row * chans + ch;
  endfunction

endpackage

// File: rtl/led_frame_bank.sv
module led_frame_bank #(
  parameter int DEPTH      = 48,
  parameter int DUTY_W     = 5,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DUTY_W-1:0] wr_duty,
  input  logic              swap,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DUTY_W-1:0] rd_duty
);

  logic wr_ok;
  assign wr_ok = wr_en && (int'(wr_idx) < DEPTH);

  generate
    if (DOUBLE_BUF) begin : g_dbuf
      logic [DUTY_W-1:0] front [DEPTH];
      logic [DUTY_W-1:0] back  [DEPTH];

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) begin
            front[i] <= '0;
            back[i]  <= '0;
          end
        end else begin
          // Whole-frame transfer reads the back copy before this edge's write.
          if (swap) begin
            for (int i = 0; i < DEPTH; i++) front[i] <= back[i];
          end
          if (wr_ok) back[wr_idx] <= wr_duty;
        end
      end

      assign rd_duty = front[rd_idx];
    end else begin : g_single
      logic [DUTY_W-1:0] store [DEPTH];
      logic unused_swap;
      assign unused_swap = swap;

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) store[i] <= '0;
        end else if (wr_ok) begin
          store[wr_idx] <= wr_duty;
        end
      end

      // Refresh read sees the old value in the write cycle; no stall.
      assign rd_duty = store[rd_idx];
    end
  endgenerate

endmodule

// File: rtl/led_scan_seq.sv
module led_scan_seq
  import led_scan_pkg::*;
#(
  parameter int ROWS      = 3,
  parameter int CH        = 16,
  parameter int DUTY_W    = 5,
  parameter int BLANK_CYC = 2,
  localparam int ROW_W    = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CH_W     = (CH > 1) ? $clog2(CH) : 1,
  localparam int BL_W     = $clog2(BLANK_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  output logic              sclk,
  output logic              latch,
  output logic              blank,
  output logic [ROW_W-1:0]  shift_row,
  output logic [ROW_W-1:0]  disp_row,
  output logic [CH_W-1:0]   bit_idx,
  output logic [DUTY_W-1:0] pwm,
  output logic              frame_end,
  output logic              pwm_wrap
);

  scan_state_t     st;
  logic            phase;
  logic [BL_W-1:0] bcnt;
  logic            blank_done;
  logic            last_bit;

  assign blank_done = (bcnt == BL_W'(BLANK_CYC - 1));
  assign last_bit   = (bit_idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_BLANK;
      phase     <= 1'b0;
      bcnt      <= '0;
      bit_idx   <= CH_W'(CH - 1);
      shift_row <= '0;
      disp_row  <= '0;
      pwm       <= '0;
    end else begin
      unique case (st)
        ST_BLANK: begin
          if (blank_done) begin
            st      <= ST_SHIFT;
            bcnt    <= '0;
            phase   <= 1'b0;
            bit_idx <= CH_W'(CH - 1);
          end else begin
            bcnt <= bcnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          phase <= ~phase;
          if (phase) begin
            if (last_bit) st <= ST_LATCH;
            else          bit_idx <= bit_idx - 1'b1;
          end
        end
        ST_LATCH: begin
          disp_row  <= shift_row;
          shift_row <= ROW_W'(row_after(int'(shift_row), ROWS));
          if (frame_end) pwm <= pwm + 1'b1;
          st   <= ST_BLANK;
          bcnt <= '0;
        end
        default: st <= ST_BLANK;
      endcase
    end
  end

  assign sclk      = (st == ST_SHIFT) && phase;
  assign latch     = (st == ST_LATCH);
  assign blank     = (st == ST_BLANK);
  assign frame_end = latch && (shift_row == ROW_W'(ROWS - 1));
  assign pwm_wrap  = frame_end && (pwm == '1);

endmodule

// File: rtl/led_scan_core.sv
module led_scan_core
  import led_scan_pkg::*;
#(
  parameter int CHIPS      = 8,
  parameter int ROWS       = 3,
  parameter int CH         = 16,
  parameter int DUTY_W     = 5,
  parameter int BLANK_CYC  = 2,
  parameter bit DOUBLE_BUF = 1'b1,
  localparam int CHIP_W    = (CHIPS > 1) ? $clog2(CHIPS) : 1,
  localparam int ROW_W     = (ROWS > 1) ? $clog2(ROWS) : 1,
  localparam int CH_W      = (CH > 1) ? $clog2(CH) : 1,
  localparam int DEPTH     = ROWS * CH,
  localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [CHIP_W-1:0] wr_chip,
  input  logic [ROW_W-1:0]  wr_row,
  input  logic [CH_W-1:0]   wr_ch,
  input  logic [DUTY_W-1:0] wr_duty,
  output logic              drv_sclk,
  output logic [CHIPS-1:0]  drv_sdat,
  output logic              drv_latch,
  output logic              drv_blank,
  output logic [ROWS-1:0]   row_sel
);

  // Named internal events, also watched by the checker.
  logic [ROW_W-1:0]  shift_row;
  logic [ROW_W-1:0]  disp_row;
  logic [CH_W-1:0]   bit_idx;
  logic [DUTY_W-1:0] pwm;
  logic              frame_end;
  logic              pwm_wrap;
  logic              swap;
  logic [IDX_W-1:0]  rd_idx;
  logic [IDX_W-1:0]  wr_idx;
  logic [DUTY_W-1:0] rd_duty [CHIPS];

  led_scan_seq #(
    .ROWS(ROWS), .CH(CH), .DUTY_W(DUTY_W), .BLANK_CYC(BLANK_CYC)
  ) u_seq (
    .clk(clk), .rst(rst),
    .sclk(drv_sclk), .latch(drv_latch), .blank(drv_blank),
    .shift_row(shift_row), .disp_row(disp_row), .bit_idx(bit_idx),
    .pwm(pwm), .frame_end(frame_end), .pwm_wrap(pwm_wrap)
  );

  assign swap    = pwm_wrap;
  assign rd_idx  = IDX_W'(led_index(int'(shift_row), int'(bit_idx), CH));
  assign wr_idx  = IDX_W'(led_index(int'(wr_row), int'(wr_ch), CH));
  assign row_sel = ROWS'(1) << disp_row;

  generate
    for (genvar g = 0; g < CHIPS; g++) begin : g_chip
      logic chip_wr;
      assign chip_wr = wr_en && (int'(wr_chip) == g);

      led_frame_bank #(
        .DEPTH(DEPTH), .DUTY_W(DUTY_W), .DOUBLE_BUF(DOUBLE_BUF)
      ) u_bank (
        .clk(clk), .rst(rst),
        .wr_en(chip_wr), .wr_idx(wr_idx), .wr_duty(wr_duty),
        .swap(swap), .rd_idx(rd_idx), .rd_duty(rd_duty[g])
      );

      assign drv_sdat[g] = led_lit(int'(rd_duty[g]), int'(pwm));
    end
  endgenerate

endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
  parameter int CHIPS  = 8,
  parameter int ROWS   = 3,
  parameter int DUTY_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              latch,
  input logic              blank,
  input logic [CHIPS-1:0]  sdat,
  input logic [ROWS-1:0]   row_sel,
  input logic              frame_end,
  input logic [DUTY_W-1:0] pwm
);

  // R3: latch lasts one cycle
  a_r3_latch_single: assert property (@(posedge clk) disable iff (rst)
    latch |=> !latch);

  // R3: no shift clock or blanking during the latch
  a_r3_latch_quiet: assert property (@(posedge clk) disable iff (rst)
    latch |-> (!sclk && !blank));

  // R4: blanking follows the latch
  a_r4_blank_after_latch: assert property (@(posedge clk) disable iff (rst)
    latch |=> blank);

  // R4: exactly one row selected
  a_r4_row_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot(row_sel));

  // R4: row select only moves while blanked
  a_r4_row_moves_blanked: assert property (@(posedge clk) disable iff (rst)
    !$stable(row_sel) |-> blank);

  // R9: data held across the rising shift clock
  a_r9_data_stable: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> $stable(sdat));

  // R5: PWM steps once at a frame end
  a_r5_pwm_step: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> (pwm == $past(pwm) + 1'b1));

  // R5: PWM holds otherwise
  a_r5_pwm_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(pwm));

endmodule

bind led_scan_core led_scan_chk #(
  .CHIPS(CHIPS), .ROWS(ROWS), .DUTY_W(DUTY_W)
) u_chk (
  .clk(clk), .rst(rst),
  .sclk(drv_sclk), .latch(drv_latch), .blank(drv_blank),
  .sdat(drv_sdat), .row_sel(row_sel),
  .frame_end(frame_end), .pwm(pwm)
);

// File: tb/test_led_scan_core.sv
`timescale 1ns/1ps
module test_led_scan_core;

  localparam int CHIPS = 8, ROWS = 3, CH = 16, DUTY_W = 5, BLANK_CYC = 2;
  localparam int DEPTH = ROWS * CH;
  localparam int PMAX = (1 << DUTY_W) - 1;
  localparam int PERIOD = 1 + BLANK_CYC + 2 * CH;   // latch-to-latch cycles
  localparam int WD_CYC = 40000;

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 1'b0;
  logic [2:0] wr_chip = '0;
  logic [1:0] wr_row = '0;
  logic [3:0] wr_ch = '0;
  logic [DUTY_W-1:0] wr_duty = '0;
  logic drv_sclk, drv_latch, drv_blank;
  logic [CHIPS-1:0] drv_sdat;
  logic [ROWS-1:0] row_sel;

  always #2 clk = ~clk;   // 250 MHz

  led_scan_core i_led_scan_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_chip(wr_chip), .wr_row(wr_row),
    .wr_ch(wr_ch), .wr_duty(wr_duty), .drv_sclk(drv_sclk), .drv_sdat(drv_sdat),
    .drv_latch(drv_latch), .drv_blank(drv_blank), .row_sel(row_sel)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  // Reference model: back copy written by the host, front copy displayed.
  int front_m [CHIPS][DEPTH];
  int back_m  [CHIPS][DEPTH];
  int m_row = 0, m_pwm = 0, m_frame = 0;
  int lat_row = -1, lat_pwm = -1, lat_frame = -1;
  logic [CHIPS-1:0] bit_q [$];   // scoreboard of captured shift bits

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  function automatic int pattern(int c, int r, int ch);
    return (c * 7 + r * 5 + ch * 3 + 1) % (PMAX + 1);
  endfunction

  // Driver: one host write, applied to the model at the edge that stores it (R6).
  task automatic host_write(input int c, input int r, input int ch, input int d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_chip = 3'(c); wr_row = 2'(r); wr_ch = 4'(ch); wr_duty = DUTY_W'(d);
    @(posedge clk);
    back_m[c][r * CH + ch] = d;
    #1 wr_en = 1'b0;
  endtask

  // Monitor: captures shift bits, checks rows at each latch, blanking after it.
  int cyc = 0, last_rise = -1, bl_cnt = 0;
  bit prev_sclk = 0, bl_track = 0;
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (drv_sclk && !prev_sclk) begin
        bit_q.push_back(drv_sdat);
        if (bit_q.size() > 1)   // R9: one rise every two cycles
          check(cyc - last_rise == 2, "R9 sclk period", cyc - last_rise, 2);
        last_rise = cyc;
      end
      prev_sclk = drv_sclk;
      if (bl_track) begin
        if (drv_blank) begin
          bl_cnt++;
          if (bl_cnt == 1)
            check(row_sel == ROWS'(1 << lat_row), "R4 row_sel after latch", int'(row_sel), 1 << lat_row);
        end else begin
          check(bl_cnt == BLANK_CYC, "R4 blank length", bl_cnt, BLANK_CYC);
          bl_track = 0;
        end
      end
      if (drv_latch) begin
        check(bit_q.size() == CH, "R3 bits before latch", bit_q.size(), CH);
        if (bit_q.size() == CH) begin
          for (int c = 0; c < CHIPS; c++) begin
            int got = 0, exp = 0;
            for (int k = 0; k < CH; k++) begin
              got = (got << 1) | int'(bit_q[k][c]);
              exp = (exp << 1) | ((front_m[c][m_row * CH + (CH - 1 - k)] < m_pwm) ? 1 : 0);
            end
            // R2 R5 R6 R7 R8: channel 15 first, duty < level, per chip
            check(got == exp, $sformatf("R2/R5/R6/R7/R8 chip %0d row %0d pwm %0d", c, m_row, m_pwm), got, exp);
          end
        end
        bit_q.delete();
        last_rise = -1;
        lat_row = m_row; lat_pwm = m_pwm; lat_frame = m_frame;
        if (m_row == ROWS - 1) begin
          m_row = 0;
          if (m_pwm == PMAX) begin
            m_pwm = 0; m_frame++;
            front_m = back_m;   // R7: whole-frame transfer at the wrap
          end else m_pwm++;
        end else m_row++;
        bl_track = 1; bl_cnt = 0;
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", WD_CYC);
    finish_run();
  end

  initial begin
    for (int c = 0; c < CHIPS; c++)
      for (int i = 0; i < DEPTH; i++) begin front_m[c][i] = 0; back_m[c][i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    check(drv_blank == 1'b1, "R1 blank in reset", int'(drv_blank), 1);
    check(drv_sclk == 1'b0, "R1 sclk in reset", int'(drv_sclk), 0);
    check(drv_latch == 1'b0, "R1 latch in reset", int'(drv_latch), 0);
    check(row_sel == ROWS'(1), "R1 row_sel in reset", int'(row_sel), 1);
    @(posedge clk); #1 rst = 1'b0;

    // Fill back copy during frame 0; frame 0 must still show zeros (R7).
    for (int c = 0; c < CHIPS; c++)
      for (int r = 0; r < ROWS; r++)
        for (int ch = 0; ch < CH; ch++)
          host_write(c, r, ch, pattern(c, r, ch));

    wait (m_frame == 1);
    // R6: single LED updates during frame 1, including extremes.
    host_write(2, 1, 5, PMAX);
    host_write(5, 0, 15, 0);
    host_write(0, 2, 15, 20);

    // R7 corner: write in the exact wrap cycle ending frame 1.
    do begin
      @(negedge clk); #1;
    end while (!(drv_latch && lat_frame == 1 && lat_pwm == PMAX && lat_row == ROWS - 2));
    repeat (PERIOD - 1) @(posedge clk);
    host_write(0, 2, 15, 3);
    check(m_frame == 2, "R7 write placed in wrap cycle", m_frame, 2);
    check(front_m[0][2 * CH + 15] == 20, "R7 front keeps pre-write value", front_m[0][2 * CH + 15], 20);

    wait (m_frame == 3);
    check(front_m[0][2 * CH + 15] == 3, "R7 late write shown next frame", front_m[0][2 * CH + 15], 3);
    repeat (4 * PERIOD) @(posedge clk);
    finish_run();
  end

endmodule